// File: doc/BRIEF.md
# System Tick Compare Interrupt Timer

This block keeps a free-running 63-bit system tick counter and two 64-bit compare registers. One compare serves the supervisor and the other the hypervisor. The counter advances by one in each cycle where the tick enable input is high. Each compare register holds a 63-bit match value in its low bits and a disable flag in its top bit.

When an increment brings the counter onto the supervisor match value, and that compare is not disabled, the block raises a one-cycle request. A neighbouring soft interrupt register uses this request to set its system-tick bit, bit 16. When the same thing happens for the hypervisor compare, the block sets a sticky pending flag. The hypervisor interrupt line follows that flag until software writes it back to zero. While the strand is halted, the hypervisor compare raises nothing.

Software reaches the counter, both compare registers and the pending flag through a single write port and a combinational read port. Writing the counter lets software position it anywhere, including just below the wrap point.

Top module: `stick_cmp_timer`

## Requirements
- R1: After reset the counter reads 0, both compare registers read 0x8000_0000_0000_0000 (disabled), the pending flag reads 0, and `sv_set_req` and `hv_irq` are low.
- R2: With `tick_en` high the counter increases by one per cycle, and it holds its value while `tick_en` is low. It wraps from 2^63-1 to 0.
- R3: Register select codes are: 0 for the counter (writes load bits 62:0, and bit 63 reads 0), 1 for the supervisor compare, 2 for the hypervisor compare, and 3 for the pending flag (bit 0 is stored and the other bits read 0). `rd_data` shows the selected register in the same cycle. A write to the counter takes priority over an increment in that cycle.
- R4: When an increment makes the counter equal bits 62:0 of the supervisor compare and bit 63 is clear, `sv_set_req` is high for exactly the first cycle in which the counter holds that value.
- R5: A compare register with bit 63 set produces no event.
- R6: A hypervisor match sets the pending flag. `hv_irq` equals the flag and stays high until software writes 0 to select code 3.
- R7: A hypervisor match whose increment happens while `halted` is high leaves the pending flag unchanged. The supervisor compare is not affected by `halted`.
- R8: Events come only from increments. A compare value at or behind the counter when it is written raises nothing until the counter wraps around and reaches it.
- R9: While `tick_en` is held low with the counter sitting on the compare value, the request is not repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance the counter this cycle |
| halted | input | 1 | Strand halted; blocks hypervisor events |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 64 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 64 | Selected register contents |
| sv_set_req | output | 1 | One-cycle request to set soft interrupt bit 16 |
| hv_irq | output | 1 | Hypervisor interrupt, level from the sticky pending flag |

## Verification
The bound checker checks the following on every cycle:
- the counter's single-step advance and its wrap;
- that a supervisor request lines up with the counter sitting on the compare value;
- that no request follows a compare that was disabled;
- that a request never repeats on the next cycle;
- that the pending flag stays set until software writes it;
- that a halted strand never raises it.

Some behaviour only the directed scenarios can show. These are the exact cycle and counter value of each event, the silence of a compare value left behind the counter until the wrap, and the reset values seen through the read port. The same holds for a write that lands exactly on the current count.

// File: rtl/stc_pkg.sv
package stc_pkg;
    localparam int CNT_W = 63;
    localparam int REG_W = CNT_W + 1;
    localparam int SEL_W = 2;
    localparam int NUM_CMP = 2;
    localparam int SV_IDX = 0;
    localparam int HV_IDX = 1;

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [REG_W-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_COUNT   = 2'd0,
        SEL_SV_CMP  = 2'd1,
        SEL_HV_CMP  = 2'd2,
        SEL_HV_PEND = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic   off;
        count_t value;
    } cmp_reg_t;

    localparam cmp_reg_t CMP_RESET = '{off: 1'b1, value: '0};

    function automatic word_t widen_count(count_t c);
        return {1'b0, c};
    endfunction

    function automatic reg_sel_e cmp_sel(int idx);
        return (idx == SV_IDX) ? SEL_SV_CMP : SEL_HV_CMP;
    endfunction
endpackage

// File: rtl/stc_counter.sv
module stc_counter
    import stc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_en,
    input  logic   load,
    input  count_t load_val,
    output count_t count,
    output count_t count_inc,
    output logic   step
);
    count_t count_q;

    assign count_inc = count_q + count_t'(1);
    assign step      = tick_en & ~load;
    assign count     = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (tick_en) begin
            count_q <= count_inc;
        end
    end
endmodule

// File: rtl/stc_compare.sv
module stc_compare
    import stc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  word_t    wr_data,
    input  logic     step,
    input  count_t   count_inc,
    input  logic     allow,
    output cmp_reg_t cfg,
    output logic     hit
);
    cmp_reg_t cfg_q;
    logic     hit_q;
    logic     arrive;

    assign arrive = step & ~cfg_q.off & (count_inc == cfg_q.value);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CMP_RESET;
            hit_q <= 1'b0;
        end else begin
            if (wr) begin
                cfg_q <= cmp_reg_t'(wr_data);
            end
            hit_q <= arrive & allow;
        end
    end

    assign cfg = cfg_q;
    assign hit = hit_q;
endmodule

// File: rtl/stc_pending.sv
module stc_pending (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic wr,
    input  logic wr_bit,
    output logic pend
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (set) begin
            pend_q <= 1'b1;
        end else if (wr) begin
            pend_q <= wr_bit;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/stick_cmp_timer.sv
module stick_cmp_timer
    import stc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        halted,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [63:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [63:0] rd_data,
    output logic        sv_set_req,
    output logic        hv_irq
);
    reg_sel_e wsel;
    reg_sel_e rsel;
    count_t   count_q;
    count_t   count_inc;
    logic     step;
    logic     pend_q;
    cmp_reg_t cmp_cfg [NUM_CMP];
    logic     cmp_hit [NUM_CMP];

    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    stc_counter u_count (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .load      (wr_en && wsel == SEL_COUNT),
        .load_val  (count_t'(wr_data[CNT_W-1:0])),
        .count     (count_q),
        .count_inc (count_inc),
        .step      (step)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        logic allow_i;
        if (i == HV_IDX) begin : g_hv_gate
            assign allow_i = ~halted;
        end else begin : g_open
            assign allow_i = 1'b1;
        end
        stc_compare u_cmp (
            .clk       (clk),
            .rst       (rst),
            .wr        (wr_en && wsel == cmp_sel(i)),
            .wr_data   (word_t'(wr_data)),
            .step      (step),
            .count_inc (count_inc),
            .allow     (allow_i),
            .cfg       (cmp_cfg[i]),
            .hit       (cmp_hit[i])
        );
    end

    stc_pending u_pend (
        .clk    (clk),
        .rst    (rst),
        .set    (cmp_hit[HV_IDX]),
        .wr     (wr_en && wsel == SEL_HV_PEND),
        .wr_bit (wr_data[0]),
        .pend   (pend_q)
    );

    always_comb begin
        unique case (rsel)
            SEL_COUNT:   rd_data = widen_count(count_q);
            SEL_SV_CMP:  rd_data = cmp_cfg[SV_IDX];
            SEL_HV_CMP:  rd_data = cmp_cfg[HV_IDX];
            SEL_HV_PEND: rd_data = {{(REG_W-1){1'b0}}, pend_q};
            default:     rd_data = '0;
        endcase
    end

    assign sv_set_req = cmp_hit[SV_IDX];
    assign hv_irq     = pend_q;
endmodule

// File: rtl/stc_timer_checker.sv
module stc_timer_checker
    import stc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_en,
    input logic       halted,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic       sv_set_req,
    input logic       hv_irq,
    input count_t     cnt,
    input cmp_reg_t   sv_cfg
);
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(tick_en) && !$past(wr_en && wr_sel == SEL_COUNT))
        |-> cnt == count_t'($past(cnt) + count_t'(1)));

    a_r4_pulse_on_value: assert property (@(posedge clk) disable iff (rst)
        (sv_set_req && !$past(wr_en && wr_sel == SEL_SV_CMP)) |-> cnt == sv_cfg.value);

    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        sv_set_req |-> !$past(sv_cfg.off));

    a_r9_no_repeat: assert property (@(posedge clk) disable iff (rst)
        (sv_set_req && !(wr_en && wr_sel == SEL_SV_CMP)) |=> !sv_set_req);

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (hv_irq && !(wr_en && wr_sel == SEL_HV_PEND)) |=> hv_irq);

    a_r7_halt_blocks: assert property (@(posedge clk) disable iff (rst)
        $rose(hv_irq) |-> (!$past(halted) || $past(wr_en && wr_sel == SEL_HV_PEND)));
endmodule

bind stick_cmp_timer stc_timer_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .halted     (halted),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .sv_set_req (sv_set_req),
    .hv_irq     (hv_irq),
    .cnt        (count_q),
    .sv_cfg     (cmp_cfg[0])
);

// File: tb/stick_cmp_timer_test.sv
module stick_cmp_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        halted = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [63:0] rd_data;
    logic        sv_set_req;
    logic        hv_irq;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    logic [63:0] at_pulse = '0;
    bit finished = 1'b0;

    localparam logic [63:0] OFF = 64'h8000_0000_0000_0000;

    always #2.5 clk = ~clk;

    stick_cmp_timer uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .halted(halted),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .sv_set_req(sv_set_req), .hv_irq(hv_irq)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [63:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [63:0] v);
        rd_sel = sel; #1; v = rd_data;
    endtask

    task automatic run(int n, logic en);
        pulses = 0;
        rd_sel = 2'd0;
        tick_en = en;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (sv_set_req) begin
                pulses++;
                at_pulse = rd_data;
            end
        end
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(2'd0, v); check("R1 counter", v, 64'd0);
        rd(2'd1, v); check("R1 sv compare", v, OFF);
        rd(2'd2, v); check("R1 hv compare", v, OFF);
        rd(2'd3, v); check("R1 pending", v, 64'd0);
        check("R1 outputs", {62'd0, sv_set_req, hv_irq}, 64'd0);
    endtask

    task automatic t_count();
        logic [63:0] v;
        run(5, 1'b1);
        rd(2'd0, v); check("R2 five steps", v, 64'd5);
        run(3, 1'b0);
        rd(2'd0, v); check("R2 hold", v, 64'd5);
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(2'd0, v); check("R3 counter load bit63 reads 0", v, 64'h7FFF_FFFF_FFFF_FFFE);
        run(3, 1'b1);
        rd(2'd0, v); check("R2 wrap", v, 64'd1);
        wr(2'd3, 64'hFFFF_FFFF_FFFF_FFF0);
        rd(2'd3, v); check("R3 pending bit0 only", v, 64'd0);
    endtask

    task automatic t_sv();
        wr(2'd0, 64'd10);
        wr(2'd1, 64'd13);
        run(8, 1'b1);
        check("R4 one pulse", 64'(pulses), 64'd1);
        check("R4 counter at pulse", at_pulse, 64'd13);
    endtask

    task automatic t_disable();
        wr(2'd0, 64'd10);
        wr(2'd1, OFF | 64'd13);
        wr(2'd2, OFF | 64'd12);
        run(8, 1'b1);
        check("R5 disabled sv", 64'(pulses), 64'd0);
        check("R5 disabled hv", {63'd0, hv_irq}, 64'd0);
    endtask

    task automatic t_hold();
        wr(2'd0, 64'd20);
        wr(2'd1, 64'd22);
        run(2, 1'b1);
        check("R9 reached", {63'd0, sv_set_req}, 64'd1);
        run(4, 1'b0);
        check("R9 no repeat", 64'(pulses), 64'd0);
    endtask

    task automatic t_behind();
        wr(2'd0, 64'd60);
        wr(2'd1, 64'd60);
        run(3, 1'b0);
        check("R8 equal on write idle", 64'(pulses), 64'd0);
        run(2, 1'b1);
        check("R8 equal on write ticking", 64'(pulses), 64'd0);
        wr(2'd0, 64'd5);
        wr(2'd1, 64'd1);
        run(10, 1'b1);
        check("R8 behind stays quiet", 64'(pulses), 64'd0);
        wr(2'd0, 64'h7FFF_FFFF_FFFF_FFFE);
        run(4, 1'b1);
        check("R8 fires after wrap", 64'(pulses), 64'd1);
        check("R8 counter at pulse", at_pulse, 64'd1);
    endtask

    task automatic t_hv();
        logic [63:0] v;
        wr(2'd0, 64'd30);
        wr(2'd2, 64'd33);
        run(5, 1'b1);
        check("R6 irq set", {63'd0, hv_irq}, 64'd1);
        rd(2'd3, v); check("R6 pending reads 1", v, 64'd1);
        run(5, 1'b1);
        check("R6 sticky", {63'd0, hv_irq}, 64'd1);
        wr(2'd3, 64'd0);
        check("R6 cleared by write", {63'd0, hv_irq}, 64'd0);
    endtask

    task automatic t_halt();
        wr(2'd0, 64'd40);
        wr(2'd2, 64'd42);
        wr(2'd1, 64'd42);
        halted = 1'b1;
        run(5, 1'b1);
        halted = 1'b0;
        check("R7 halted hv quiet", {63'd0, hv_irq}, 64'd0);
        check("R7 sv unaffected", 64'(pulses), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_count();
        t_sv();
        t_disable();
        t_hold();
        t_behind();
        t_hv();
        t_halt();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule